// File: doc/BRIEF.md
# Three-Address Memory-to-Memory Multicycle Processor

A compact processor core with no register file. Every instruction names a destination word and two source words, all held in one unified memory. The core runs a fixed fetch, decode, operand fetch, execute and write-back loop. It drives a single-port synchronous memory that returns read data one cycle after the address is presented. Because there is only one port, the two operand reads take separate cycles. An ALU instruction therefore occupies six clock cycles: fetch, decode, two operand reads, execute and write. A jump or branch occupies five cycles, because it has no write.

The instruction word is 32 bits wide. The opcode sits in bits [31:24], the destination word index in [23:16], source-1 in [15:8] and source-2 in [7:0]. A word index is turned into a byte address by multiplying it by 4. The core stops on a halt instruction or on any opcode it does not know, and raises its halt output. To use it, a system loads program and data into memory, releases reset and waits for the halt output.

Top module: `m2m_core`

## Requirements
- R1: While reset is held low, the halt output is 0, the write enable is 0 and the memory address is 0. The first fetch after reset reads byte address 0.
- R2: Each instruction word is read from the byte address held in the program counter, and the counter then advances by 4. Instructions placed in consecutive words run in order.
- R3: An ALU instruction takes exactly 6 cycles and performs exactly one memory write, in its last cycle. JMP and BEQ take 5 cycles. From reset release until halt is raised, a program of N ALU instructions followed by a halt takes 6N+2 cycles.
- R4: Opcode 0x01 stores SRC1+SRC2 and opcode 0x02 stores SRC1-SRC2 at the destination, both modulo 2^32. For example, 42 and 12 give 54 for the add.
- R5: Opcode 0x03 stores SRC1 AND SRC2, opcode 0x04 stores SRC1 OR SRC2, and opcode 0x05 stores NOT SRC1. Opcode 0x05 ignores SRC2.
- R6: Opcode 0x10 (JMP) loads the program counter with the destination field times 4 and writes no memory.
- R7: Opcode 0x11 (BEQ) loads the program counter with the destination field times 4 when SRC1 equals SRC2. Otherwise execution falls through to the next word. Neither outcome writes memory.
- R8: Opcode 0xFF raises the halt output. From then until reset, the write enable stays 0 and the memory address stays constant.
- R9: Any opcode other than those listed above, 0x00 and 0x7E included, behaves exactly like 0xFF.
- R10: Both sources are read before the destination is written. A destination equal to a source therefore computes from the old value.
- R11: The fields sit at opcode [31:24], destination [23:16], source-1 [15:8] and source-2 [7:0]. Word index k is accessed at byte address 4k, so indices up to 255 are reachable and address bits [1:0] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 10 | Byte address presented to the memory |
| mem_wdata | output | 32 | Data to store when mem_we is high |
| mem_we | output | 1 | Write enable for the current cycle |
| mem_rdata | input | 32 | Read data, valid one cycle after its address |
| halted | output | 1 | High once a halt or unknown opcode has been decoded |

## Verification
In the execute cycle, the second operand arrives on the read bus at the same moment that the ALU result or the branch decision is formed. A program-counter overwrite and the capture of that operand therefore fall in the same cycle. The bench provokes this with BEQ on equal and on unequal cells, and with in-place instructions whose destination equals a source. It judges the outcome from the contents of the result cells, from cells that must stay untouched, and from exact cycle counts up to halt.

// File: rtl/m2m_pkg.sv
// Package m2m_pkg
// Shared phase encoding, ALU operation codes, opcode constants and the
// decoded control bundle for the memory-to-memory core.
package m2m_pkg;

    typedef enum logic [2:0] {
        PH_IF   = 3'd0,
        PH_ID   = 3'd1,
        PH_DF1  = 3'd2,
        PH_DF2  = 3'd3,
        PH_EX   = 3'd4,
        PH_WR   = 3'd5,
        PH_HALT = 3'd6
    } phase_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_NOT = 3'd4
    } alu_op_t;

    localparam logic [7:0] OPC_ADD  = 8'h01;
    localparam logic [7:0] OPC_SUB  = 8'h02;
    localparam logic [7:0] OPC_AND  = 8'h03;
    localparam logic [7:0] OPC_OR   = 8'h04;
    localparam logic [7:0] OPC_NOT  = 8'h05;
    localparam logic [7:0] OPC_JMP  = 8'h10;
    localparam logic [7:0] OPC_BEQ  = 8'h11;
    localparam logic [7:0] OPC_HALT = 8'hFF;

    typedef struct packed {
        alu_op_t alu_op;
        logic    is_alu;
        logic    is_jmp;
        logic    is_beq;
        logic    is_halt;
    } ctl_t;

endpackage

// File: rtl/m2m_decode.sv
// Module m2m_decode
// Turns an opcode into a control bundle. It is purely combinational.
// Assumes exactly one class flag is set for every input value; any
// opcode that is not recognised is classed as a halt.
module m2m_decode
    import m2m_pkg::*;
#(
    parameter int OPC_W = 8
)(
    input  logic [OPC_W-1:0] opcode,
    output ctl_t             ctl
);

    localparam logic [OPC_W-1:0] K_ADD = OPC_W'(OPC_ADD);
    localparam logic [OPC_W-1:0] K_SUB = OPC_W'(OPC_SUB);
    localparam logic [OPC_W-1:0] K_AND = OPC_W'(OPC_AND);
    localparam logic [OPC_W-1:0] K_OR  = OPC_W'(OPC_OR);
    localparam logic [OPC_W-1:0] K_NOT = OPC_W'(OPC_NOT);
    localparam logic [OPC_W-1:0] K_JMP = OPC_W'(OPC_JMP);
    localparam logic [OPC_W-1:0] K_BEQ = OPC_W'(OPC_BEQ);

    // Classify the opcode; unknown values (0xFF included) fall to halt.
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        case (opcode)
            K_ADD: begin ctl.is_alu = 1'b1; ctl.alu_op = ALU_ADD; end
            K_SUB: begin ctl.is_alu = 1'b1; ctl.alu_op = ALU_SUB; end
            K_AND: begin ctl.is_alu = 1'b1; ctl.alu_op = ALU_AND; end
            K_OR:  begin ctl.is_alu = 1'b1; ctl.alu_op = ALU_OR;  end
            K_NOT: begin ctl.is_alu = 1'b1; ctl.alu_op = ALU_NOT; end
            K_JMP: ctl.is_jmp  = 1'b1;
            K_BEQ: ctl.is_beq  = 1'b1;
            default: ctl.is_halt = 1'b1;
        endcase
    end

endmodule

// File: rtl/m2m_alu.sv
// Module m2m_alu
// Combinational arithmetic/logic unit. It also produces an equality flag
// that branch resolution uses. Arithmetic wraps modulo 2^DATA_W.
module m2m_alu
    import m2m_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              eq
);

    // Select the result for the requested operation.
    always_comb begin
        case (op)
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_NOT: res = ~a;
            default: res = '0;
        endcase
    end

    // Equality of the two operands, used by the conditional branch.
    always_comb eq = (a == b);

endmodule

// File: rtl/m2m_seq.sv
// Module m2m_seq
// Phase sequencer and program counter. It steps through fetch, decode,
// two operand reads, execute and write, and skips the write for jump and
// branch. The class flags are expected to come from the fresh instruction
// in decode and from the latched instruction in execute.
module m2m_seq
    import m2m_pkg::*;
#(
    parameter int ADDR_W = 10
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_alu,
    input  logic              is_jmp,
    input  logic              is_beq,
    input  logic              is_halt,
    input  logic              br_eq,
    input  logic [ADDR_W-1:0] tgt_addr,
    output phase_t            phase,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(4);

    phase_t            phase_q, phase_d;
    logic [ADDR_W-1:0] pc_q, pc_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IF:   phase_d = PH_ID;
            PH_ID:   phase_d = is_halt ? PH_HALT : PH_DF1;
            PH_DF1:  phase_d = PH_DF2;
            PH_DF2:  phase_d = PH_EX;
            PH_EX:   phase_d = is_alu ? PH_WR : PH_IF;
            PH_WR:   phase_d = PH_IF;
            PH_HALT: phase_d = PH_HALT;
            default: phase_d = PH_HALT;
        endcase
    end

    // Next program counter: step on fetch, redirect on a taken jump or branch.
    always_comb begin
        pc_d = pc_q;
        if (phase_q == PH_IF)
            pc_d = pc_q + PC_STEP;
        else if (phase_q == PH_EX && (is_jmp || (is_beq && br_eq)))
            pc_d = tgt_addr;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IF;
            pc_q    <= '0;
        end else begin
            phase_q <= phase_d;
            pc_q    <= pc_d;
        end
    end

    assign phase = phase_q;
    assign pc    = pc_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IF) |=> (pc_q == $past(pc_q) + PC_STEP)); // R2
    AST_DF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DF1) |=> (phase_q == PH_DF2)); // R3
    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EX && is_jmp) |=> (pc_q == $past(tgt_addr))); // R6
    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EX && is_beq && !br_eq) |=> $stable(pc_q)); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HALT) |=> (phase_q == PH_HALT && $stable(pc_q))); // R8

endmodule

// File: rtl/m2m_core.sv
// Module m2m_core
// Top of the three-address memory-to-memory processor. It holds the
// instruction register, the first-operand register and the result
// register, and it multiplexes the memory address. It assumes a
// single-port synchronous memory whose read data is valid one cycle
// after the address.
module m2m_core
    import m2m_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  int FIELD_W = 8,
    localparam int ADDR_W  = FIELD_W + 2
)(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    localparam int OPC_W = DATA_W - 3 * FIELD_W;

    phase_t            phase;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir_q, opa_q, res_q, alu_res;
    logic [OPC_W-1:0]  dec_opc;
    logic [FIELD_W-1:0] dst_f, src1_f, src2_f;
    logic [ADDR_W-1:0] dst_addr, src1_addr, src2_addr;
    ctl_t              ctl;
    logic              alu_eq;

    // Field extraction from the latched instruction word.
    always_comb begin
        dst_f  = ir_q[3*FIELD_W-1 -: FIELD_W];
        src1_f = ir_q[2*FIELD_W-1 -: FIELD_W];
        src2_f = ir_q[FIELD_W-1:0];
    end

    // Word index to byte address.
    always_comb begin
        dst_addr  = {dst_f,  2'b00};
        src1_addr = {src1_f, 2'b00};
        src2_addr = {src2_f, 2'b00};
    end

    // Decode the fresh read data in the decode phase, the latched word otherwise.
    always_comb
        dec_opc = (phase == PH_ID) ? mem_rdata[DATA_W-1 -: OPC_W]
                                   : ir_q[DATA_W-1 -: OPC_W];

    m2m_decode #(.OPC_W(OPC_W)) u_decode (
        .opcode (dec_opc),
        .ctl    (ctl)
    );

    m2m_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (ctl.alu_op),
        .a   (opa_q),
        .b   (mem_rdata),
        .res (alu_res),
        .eq  (alu_eq)
    );

    m2m_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_alu   (ctl.is_alu),
        .is_jmp   (ctl.is_jmp),
        .is_beq   (ctl.is_beq),
        .is_halt  (ctl.is_halt),
        .br_eq    (alu_eq),
        .tgt_addr (dst_addr),
        .phase    (phase),
        .pc       (pc)
    );

    // Latch the instruction, first operand and result in their phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            opa_q <= '0;
            res_q <= '0;
        end else begin
            if (phase == PH_ID)  ir_q  <= mem_rdata;
            if (phase == PH_DF2) opa_q <= mem_rdata;
            if (phase == PH_EX)  res_q <= alu_res;
        end
    end

    // Memory address per phase; the PC is held while halted.
    always_comb begin
        case (phase)
            PH_DF1:  mem_addr = src1_addr;
            PH_DF2:  mem_addr = src2_addr;
            PH_WR:   mem_addr = dst_addr;
            default: mem_addr = pc;
        endcase
    end

    // Write strobe, write data and halt flag.
    always_comb begin
        mem_we    = (phase == PH_WR);
        mem_wdata = res_q;
        halted    = (phase == PH_HALT);
    end

    AST_WRITE_AFTER_EX: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(phase) == PH_EX)); // R3
    AST_NO_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EX && !ctl.is_alu) |=> !mem_we); // R7
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && $stable(mem_addr))); // R8
    AST_OPA_FROM_DF: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EX) |-> ($past(phase) == PH_DF2)); // R10

endmodule

// File: tb/m2m_core_bench.sv
`timescale 1ns/1ps
module m2m_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic [31:0] mem_rdata;
    logic        halted;

    logic [31:0] mem [0:255];
    logic        bd_we = 1'b0;
    logic        bd_clr = 1'b0;
    logic [7:0]  bd_idx = '0;
    logic [31:0] bd_dat = '0;

    int wr_cnt;
    int misal;
    int tests = 0;
    int fails = 0;
    bit timeout = 0;

    always #4 clk = ~clk;

    m2m_core u_m2m_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Memory model with a backdoor port that takes priority.
    always @(posedge clk) begin
        if (bd_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else if (bd_we) begin
            mem[bd_idx] <= bd_dat;
        end else if (mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[9:2]];
    end

    // Monitors: write count and misaligned addresses since reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= 0;
            misal  <= 0;
        end else begin
            if (mem_we) wr_cnt <= wr_cnt + 1;
            if (mem_addr[1:0] != 2'b00) misal <= misal + 1;
        end
    end

    function automatic logic [31:0] enc(input logic [7:0] op, input logic [7:0] d,
                                        input logic [7:0] a, input logic [7:0] b);
        return {op, d, a, b};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] val);
        bd_we = 1'b1; bd_idx = idx[7:0]; bd_dat = val;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic start_test();
        @(negedge clk);
        rst_n = 1'b0;
        bd_clr = 1'b1;
        @(negedge clk);
        bd_clr = 1'b0;
    endtask

    task automatic run_prog(output int cyc);
        rst_n = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!halted && cyc < 400);
    endtask

    task automatic test_reset();
        int cyc;
        start_test();
        load(0, enc(8'hFF, 0, 0, 0));
        @(negedge clk);
        check("R1 halt in reset", {31'b0, halted}, 32'd0);
        check("R1 we in reset", {31'b0, mem_we}, 32'd0);
        check("R1 addr in reset", {22'b0, mem_addr}, 32'd0);
        run_prog(cyc);
        check("R1 halt-at-0 cycles", cyc, 2);
    endtask

    task automatic test_alu();
        int cyc;
        start_test();
        load(64, 42); load(65, 12);
        load(66, 32'hF0F000FF); load(67, 32'h0FF00F0F);
        load(68, 32'hFFFFFFFF); load(69, 2);
        load(0, enc(8'h01, 80, 64, 65));
        load(1, enc(8'h02, 81, 65, 64));
        load(2, enc(8'h03, 82, 66, 67));
        load(3, enc(8'h04, 83, 66, 67));
        load(4, enc(8'h05, 84, 66, 67));
        load(5, enc(8'h01, 85, 68, 69));
        load(6, enc(8'hFF, 0, 0, 0));
        run_prog(cyc);
        check("R4 add", mem[80], 32'd54);
        check("R4 sub wrap", mem[81], 32'hFFFFFFE2);
        check("R5 and", mem[82], 32'h00F0000F);
        check("R5 or", mem[83], 32'hFFF00FFF);
        check("R5 not ignores src2", mem[84], 32'h0F0FFF00);
        check("R4 add wrap", mem[85], 32'd1);
        check("R3 cycles 6N+2", cyc, 38);
        check("R3 one write per alu op", wr_cnt, 6);
        check("R2 sources untouched", mem[64], 32'd42);
        check("R11 aligned addresses", misal, 0);
    endtask

    task automatic test_jump();
        int cyc;
        start_test();
        load(64, 42); load(65, 12);
        load(0, enc(8'h10, 3, 0, 0));
        load(1, enc(8'h01, 80, 64, 65));
        load(2, enc(8'hFF, 0, 0, 0));
        load(3, enc(8'h02, 81, 64, 65));
        load(4, enc(8'hFF, 0, 0, 0));
        run_prog(cyc);
        check("R6 skipped cell", mem[80], 32'd0);
        check("R6 target executed", mem[81], 32'd30);
        check("R6 cycles", cyc, 13);
        check("R6 writes", wr_cnt, 1);
    endtask

    task automatic test_branch();
        int cyc;
        start_test();
        load(64, 42); load(65, 12); load(70, 42);
        load(0, enc(8'h11, 3, 64, 70));
        load(1, enc(8'h01, 80, 64, 65));
        load(2, enc(8'hFF, 0, 0, 0));
        load(3, enc(8'h11, 6, 64, 65));
        load(4, enc(8'h04, 81, 64, 65));
        load(5, enc(8'hFF, 0, 0, 0));
        load(6, enc(8'h01, 82, 64, 65));
        run_prog(cyc);
        check("R7 taken skips", mem[80], 32'd0);
        check("R7 fall-through runs", mem[81], 32'd46);
        check("R7 not-taken target idle", mem[82], 32'd0);
        check("R7 cycles", cyc, 18);
        check("R7 writes", wr_cnt, 1);
    endtask

    task automatic test_inplace();
        int cyc;
        start_test();
        load(64, 42); load(65, 12); load(253, 7); load(254, 100);
        load(0, enc(8'h01, 64, 64, 64));
        load(1, enc(8'h02, 65, 64, 65));
        load(2, enc(8'h01, 255, 254, 253));
        load(3, enc(8'hFF, 0, 0, 0));
        run_prog(cyc);
        check("R10 dst=src add", mem[64], 32'd84);
        check("R10 dst=src2 sub", mem[65], 32'd72);
        check("R11 top indices", mem[255], 32'd107);
        check("R11 aligned", misal, 0);
        check("R3 cycles", cyc, 20);
    endtask

    task automatic test_halt_hold();
        int cyc;
        logic [9:0] a0;
        bit moved;
        start_test();
        load(64, 42); load(65, 12);
        load(0, enc(8'h01, 80, 64, 65));
        load(1, enc(8'hFF, 0, 0, 0));
        load(2, enc(8'h01, 81, 64, 65));
        run_prog(cyc);
        check("R8 halted", {31'b0, halted}, 32'd1);
        check("R8 cycles", cyc, 8);
        a0 = mem_addr;
        moved = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_addr !== a0 || mem_we !== 1'b0 || halted !== 1'b1) moved = 1;
        end
        check("R8 quiet while halted", {31'b0, moved}, 32'd0);
        check("R8 next not run", mem[81], 32'd0);
        check("R8 writes", wr_cnt, 1);
    endtask

    task automatic test_bad_opcode();
        int cyc;
        start_test();
        load(64, 42); load(65, 12);
        load(0, enc(8'h01, 80, 64, 65));
        load(1, enc(8'h7E, 81, 64, 65));
        load(2, enc(8'h01, 82, 64, 65));
        run_prog(cyc);
        check("R9 0x7E halts", {31'b0, halted}, 32'd1);
        check("R9 0x7E cycles", cyc, 8);
        check("R9 0x7E no write", mem[81], 32'd0);
        check("R9 after 0x7E idle", mem[82], 32'd0);
        start_test();
        load(64, 42); load(65, 12);
        load(0, enc(8'h00, 80, 64, 65));
        run_prog(cyc);
        check("R9 0x00 cycles", cyc, 2);
        check("R9 0x00 writes", wr_cnt, 0);
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_alu();
                test_jump();
                test_branch();
                test_inplace();
                test_halt_hold();
                test_bad_opcode();
            end
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual expired expected finish");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule